// File: doc/BRIEF.md
# Periodic Tick and Interrupt Request Controller

This block raises interrupt requests for a small processor from a countdown timer that runs on a 32.768 kHz real-time clock and from a few other slow-domain event sources. Every request lives in its own flop. Only logic on the slow clock can set a request flop. The processor clears it through an asynchronous clear, so a clear never has to wait for the slow clock. The processor clock is about 10 MHz and has no fixed relation to the slow clock.

The processor uses a simple write strobe with a 2-bit address to do three things: set the timer reload value, set the enable mask, and clear selected requests. It can read back the reload value, the mask and the synchronized raw requests. The masked requests are ORed together, and the result passes through two processor-clock flops to form the single interrupt line.

The timer counts down, reloads when it reaches zero, and issues a set strobe only on the cycle it moves from a nonzero count to zero. With the default reload value the request rate is 128 Hz.

Top module: `tick_irq_ctrl`

## Requirements
- R1: While `rst` is high and once it falls, the controller is in its reset state: reload reads 255, mask reads 0, requests read 0 and `irq` is 0. The reset acts asynchronously on both clock domains.
- R2: When the reload register (address 0) holds N > 0, request bit 0 is raised once every N+1 slow-clock cycles. The default of 255 gives a 256-cycle period, which is 128 Hz from 32.768 kHz.
- R3: A request is raised only when the counter moves from a nonzero value into zero. With a reload of 0 the counter stops at zero and raises no further request after a clear.
- R4: When `src_req[k]` is high at a slow-clock edge, request bit k+1 is set at the next slow-clock edge and stays set until it is cleared.
- R5: `irq` follows the OR of request bits whose mask bit (address 1, bit i enables request i) is 1. When the mask is zero, `irq` stays 0 even with requests pending.
- R6: After a change of the masked OR, `irq` changes at the second processor-clock edge that follows it.
- R7: A processor write to address 2 clears every request bit where the written data is 1. The clear needs no slow-clock edge. Bits written as 0 are unchanged. The cleared state reads back two processor cycles after the write edge.
- R8: A clear holds its bits at zero through at least one following slow-clock edge, so it wins over a set arriving in that cycle. Once the hold ends, the bit can be set again.
- R9: Reads return the reload at address 0, the mask at address 1 and the two-flop synchronized requests at address 2. Address 3 reads 0, and bits above the field width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor clock |
| clk_rtc | input | 1 | 32.768 kHz timer clock |
| rst | input | 1 | Active-high asynchronous reset |
| wr_en | input | 1 | Register write strobe, processor domain |
| wr_addr | input | 2 | Write address: 0 reload, 1 mask, 2 clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| src_req | input | 3 | Slow-domain event inputs for request bits 1 to 3 |
| irq | output | 1 | Combined interrupt line, processor domain |

## Verification
Each result has a fixed latency in this block:
- Timer bit: set on the slow edge after the counter enters zero.
- Source bit: set one slow edge after the input is sampled.
- Readback: trails a request change by two processor cycles.
- `irq`: trails a mask write by two processor edges.
- Clear: visible at readback two processor cycles after the write.

The bench drives inputs on negative edges and counts slow and fast edges to these points. It samples at the negative edge that follows the last register on the path. Period checks compare slow-edge counts taken when `irq` rises. The synchronizer delay is a few fast cycles, far less than one slow period, so it drops out of the difference. Clears are swept across every fast-cycle phase of the slow clock, so a lost clear at any alignment would show.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
   localparam int BUS_W = 8;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_RELOAD = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_REQ    = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tick_irq_sync.sv
module tick_irq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tick_irq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("tick_irq_sync: W must be at least 1");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tick_irq_timer.sv
module tick_irq_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk_rtc,
   input  logic             rst,
   input  logic [TMR_W-1:0] reload,
   output logic             hit
);
   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] cnt_nxt;
   logic             hit_q;

   always_comb begin
      if (cnt_q == '0) cnt_nxt = reload;
      else             cnt_nxt = cnt_q - TMR_W'(1);
   end

   always_ff @(posedge clk_rtc or posedge rst) begin
      if (rst) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         // strobe only on the step into zero, never while parked there
         hit_q <= (cnt_q != '0) && (cnt_nxt == '0);
      end
   end

   assign hit = hit_q;
endmodule

// File: rtl/tick_irq_bank.sv
module tick_irq_bank #(
   parameter int N = 4
) (
   input  logic         clk_rtc,
   input  logic         rst,
   input  logic         tmr_hit,
   input  logic [N-2:0] src_in,
   input  logic [N-1:0] clr_line,
   output logic [N-1:0] req
);
   logic [N-2:0] src_q;
   logic [N-1:0] set_q;

   always_ff @(posedge clk_rtc or posedge rst) begin
      if (rst) src_q <= '0;
      else     src_q <= src_in;
   end

   assign set_q = {src_q, tmr_hit};

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk_rtc or posedge clr_line[g]) begin
         if (clr_line[g])   bit_q <= 1'b0;
         else if (set_q[g]) bit_q <= 1'b1;
      end
      assign req[g] = bit_q;
   end
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
   import tick_irq_pkg::*;
#(
   parameter int N_REQ      = 4,
   parameter int TMR_W      = 8,
   parameter int RELOAD_RST = 255,
   parameter int SYNC_STG   = 2
) (
   input  logic               clk_cpu,
   input  logic               clk_rtc,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_addr,
   input  logic [BUS_W-1:0]   wr_data,
   input  logic [SEL_W-1:0]   rd_addr,
   output logic [BUS_W-1:0]   rd_data,
   input  logic [N_REQ-2:0]   src_req,
   output logic               irq
);
   localparam int N_SRC = N_REQ - 1;

   if (N_REQ < 2 || N_REQ > BUS_W) begin : g_bad_nreq
      $error("tick_irq_ctrl: N_REQ must lie in 2..BUS_W");
   end
   if (TMR_W < 1 || TMR_W > BUS_W) begin : g_bad_tmr
      $error("tick_irq_ctrl: TMR_W must lie in 1..BUS_W");
   end
   if (RELOAD_RST < 0 || RELOAD_RST >= (1 << TMR_W)) begin : g_bad_reload
      $error("tick_irq_ctrl: RELOAD_RST does not fit TMR_W");
   end
   if (N_SRC < 1) begin : g_bad_src
      $error("tick_irq_ctrl: at least one external source required");
   end

   logic [TMR_W-1:0] reload_q;
   logic [N_REQ-1:0] mask_q;
   logic [N_REQ-1:0] clr_pend;
   logic             clr_seen;
   logic [N_REQ-1:0] clr_line;
   logic [N_REQ-1:0] req_raw;
   logic [N_REQ-1:0] req_s;
   logic             tmr_hit;
   logic             rtc_s;
   logic             rtc_d;
   logic             rtc_rise;
   logic             irq_raw;
   logic             wr_reload;
   logic             wr_mask;
   logic             wr_clr;

   assign wr_reload = wr_en && (wr_addr == SEL_RELOAD);
   assign wr_mask   = wr_en && (wr_addr == SEL_MASK);
   assign wr_clr    = wr_en && (wr_addr == SEL_REQ) && (|wr_data[N_REQ-1:0]);

   // processor-side configuration registers
   always_ff @(posedge clk_cpu or posedge rst) begin
      if (rst) begin
         reload_q <= TMR_W'(RELOAD_RST);
         mask_q   <= '0;
      end else begin
         if (wr_reload) reload_q <= wr_data[TMR_W-1:0];
         if (wr_mask)   mask_q   <= wr_data[N_REQ-1:0];
      end
   end

   // observe slow-clock edges in the processor domain to time the clear hold
   tick_irq_sync #(.W(1), .STAGES(SYNC_STG)) u_rtc_sync (
      .clk (clk_cpu),
      .rst (rst),
      .d   (clk_rtc),
      .q   (rtc_s)
   );

   always_ff @(posedge clk_cpu or posedge rst) begin
      if (rst) rtc_d <= 1'b0;
      else     rtc_d <= rtc_s;
   end
   assign rtc_rise = rtc_s & ~rtc_d;

   // registered clear strobes, released on the second observed slow edge
   always_ff @(posedge clk_cpu or posedge rst) begin
      if (rst) begin
         clr_pend <= '0;
         clr_seen <= 1'b0;
      end else if (wr_clr) begin
         clr_pend <= clr_pend | wr_data[N_REQ-1:0];
         clr_seen <= 1'b0;
      end else if ((|clr_pend) && rtc_rise) begin
         if (clr_seen) begin
            clr_pend <= '0;
            clr_seen <= 1'b0;
         end else begin
            clr_seen <= 1'b1;
         end
      end
   end

   assign clr_line = {N_REQ{rst}} | clr_pend;

   tick_irq_timer #(.TMR_W(TMR_W)) u_timer (
      .clk_rtc (clk_rtc),
      .rst     (rst),
      .reload  (reload_q),
      .hit     (tmr_hit)
   );

   tick_irq_bank #(.N(N_REQ)) u_bank (
      .clk_rtc  (clk_rtc),
      .rst      (rst),
      .tmr_hit  (tmr_hit),
      .src_in   (src_req),
      .clr_line (clr_line),
      .req      (req_raw)
   );

   assign irq_raw = |(req_raw & mask_q);

   tick_irq_sync #(.W(1), .STAGES(SYNC_STG)) u_irq_sync (
      .clk (clk_cpu),
      .rst (rst),
      .d   (irq_raw),
      .q   (irq)
   );

   tick_irq_sync #(.W(N_REQ), .STAGES(SYNC_STG)) u_req_sync (
      .clk (clk_cpu),
      .rst (rst),
      .d   (req_raw),
      .q   (req_s)
   );

   always_comb begin
      case (rd_addr)
         SEL_RELOAD: rd_data = BUS_W'(reload_q);
         SEL_MASK:   rd_data = BUS_W'(mask_q);
         SEL_REQ:    rd_data = BUS_W'(req_s);
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/tick_irq_ctrl_chk.sv
module tick_irq_ctrl_chk #(
   parameter int N = 4
) (
   input logic         clk_cpu,
   input logic         clk_rtc,
   input logic         rst,
   input logic         irq,
   input logic         tmr_hit,
   input logic [N-1:0] mask_q,
   input logic [N-1:0] clr_pend,
   input logic [N-1:0] req_raw
);
   // R1: reset forces the interrupt line low
   a_r1_reset_quiet: assert property (@(posedge clk_cpu)
      rst |=> !irq);

   // R3: the rundown strobe never lasts two slow cycles
   a_r3_single_strobe: assert property (@(posedge clk_rtc) disable iff (rst)
      tmr_hit |=> !tmr_hit);

   // R2: timer request rises only after a rundown strobe
   a_r2_req_from_rundown: assert property (@(posedge clk_rtc) disable iff (rst)
      $rose(req_raw[0]) |-> $past(tmr_hit));

   // R5: a mask held at zero keeps the line low
   a_r5_masked_quiet: assert property (@(posedge clk_cpu) disable iff (rst)
      (mask_q == '0 && $past(mask_q) == '0 && $past(mask_q, 2) == '0) |-> !irq);

   // R8: a clear held across a sample keeps its bits at zero
   a_r8_clear_holds: assert property (@(posedge clk_cpu) disable iff (rst)
      ((clr_pend & $past(clr_pend) & req_raw) == '0));
endmodule

bind tick_irq_ctrl tick_irq_ctrl_chk #(.N(N_REQ)) u_chk (
   .clk_cpu  (clk_cpu),
   .clk_rtc  (clk_rtc),
   .rst      (rst),
   .irq      (irq),
   .tmr_hit  (tmr_hit),
   .mask_q   (mask_q),
   .clr_pend (clr_pend),
   .req_raw  (req_raw)
);

// File: tb/tick_irq_ctrl_test.sv
`timescale 1ns/1ps
module tick_irq_ctrl_test;
   logic       clk_cpu = 1'b0;
   logic       clk_rtc = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [2:0] src_req = '0;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   int slow_cnt = 0;
   bit done = 1'b0;

   always #4 clk_cpu = ~clk_cpu;
   always #101.5 clk_rtc = ~clk_rtc;
   always @(posedge clk_rtc) slow_cnt <= slow_cnt + 1;

   tick_irq_ctrl uut (
      .clk_cpu (clk_cpu),
      .clk_rtc (clk_rtc),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .src_req (src_req),
      .irq     (irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk_cpu);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk_cpu);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic slow_wait(input int n);
      repeat (n) @(posedge clk_rtc);
      @(negedge clk_cpu);
   endtask

   task automatic wait_irq(input logic lvl, output int sc);
      int guard = 0;
      @(negedge clk_cpu);
      while (irq !== lvl && guard < 20000) begin
         @(negedge clk_cpu);
         guard++;
      end
      if (irq !== lvl) chk("irq wait", int'(irq), int'(lvl));
      sc = slow_cnt;
   endtask

   // one-cycle pulse on a source, returns three fast cycles after the set edge
   task automatic pulse_src(input logic [2:0] m);
      @(negedge clk_rtc); src_req = m;
      @(negedge clk_rtc); src_req = '0;
      @(posedge clk_rtc);
      repeat (3) @(negedge clk_cpu);
   endtask

   initial begin
      int v, t0, t1, t2, tx;
      repeat (5) @(negedge clk_cpu);
      rst = 1'b0;
      @(negedge clk_cpu);
      // R1 reset state
      rd(2'd0, v); chk("R1 reload", v, 255);
      rd(2'd1, v); chk("R1 mask", v, 0);
      rd(2'd2, v); chk("R1 req", v, 0);
      chk("R1 irq", int'(irq), 0);

      // R2 default period of 256 slow cycles
      wr(2'd1, 8'h01);
      wait_irq(1'b1, t0);
      wr(2'd2, 8'h01); wait_irq(1'b0, tx);
      wait_irq(1'b1, t1);
      wr(2'd2, 8'h01); wait_irq(1'b0, tx);
      wait_irq(1'b1, t2);
      chk("R2 period a", t1 - t0, 256);
      chk("R2 period b", t2 - t1, 256);

      // R2 reload 15 gives 16
      wr(2'd0, 8'd15);
      rd(2'd0, v); chk("R9 reload readback", v, 15);
      wr(2'd2, 8'h01); wait_irq(1'b0, tx);
      wait_irq(1'b1, tx);
      for (int k = 0; k < 3; k++) begin
         wr(2'd2, 8'h01); wait_irq(1'b0, tx);
         wait_irq(1'b1, t1);
         if (k > 0) chk("R2 period 16", t1 - t0, 16);
         t0 = t1;
      end

      // R3 reload 0 halts the counter at zero
      wr(2'd0, 8'd0);
      slow_wait(20);
      wr(2'd2, 8'h01);
      slow_wait(300);
      rd(2'd2, v); chk("R3 no request after halt", v, 0);
      chk("R3 irq low", int'(irq), 0);
      rd(2'd0, v); chk("R9 reload zero", v, 0);

      // R4 source timing: set one slow edge after sampling
      @(negedge clk_rtc); src_req = 3'b010;
      @(posedge clk_rtc);
      @(negedge clk_rtc); src_req = '0;
      rd(2'd2, v); chk("R4 not yet set", v, 0);
      @(posedge clk_rtc);
      repeat (3) @(negedge clk_cpu);
      rd(2'd2, v); chk("R4 bit2 set", v, 4);

      // R5 masked out
      wr(2'd1, 8'h01);
      repeat (4) @(negedge clk_cpu);
      chk("R5 masked irq", int'(irq), 0);

      // R6 exact latency after mask write
      @(negedge clk_cpu);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h04;
      @(negedge clk_cpu);
      wr_en = 1'b0;
      chk("R6 irq edge+0", int'(irq), 0);
      @(negedge clk_cpu);
      chk("R6 irq edge+1", int'(irq), 0);
      @(negedge clk_cpu);
      chk("R6 irq edge+2", int'(irq), 1);

      // R7 clear sweep over every fast phase of the slow clock
      for (int ph = 0; ph < 25; ph++) begin
         pulse_src(3'b001);
         rd(2'd2, v); chk("R4 bit1 set", v, 6);
         @(posedge clk_rtc);
         repeat (ph) @(negedge clk_cpu);
         wr(2'd2, 8'h02);
         repeat (2) @(negedge clk_cpu);
         rd(2'd2, v); chk("R7 selective clear", v, 4);
         slow_wait(4);
      end

      // R8 clear wins over a set held high, then the bit returns
      @(negedge clk_rtc); src_req = 3'b001;
      slow_wait(3);
      for (int ph = 0; ph < 8; ph++) begin
         @(posedge clk_rtc);
         repeat (ph * 3) @(negedge clk_cpu);
         wr(2'd2, 8'h02);
         repeat (2) @(negedge clk_cpu);
         rd(2'd2, v); chk("R8 clear dominates", v, 4);
         slow_wait(6);
         rd(2'd2, v); chk("R8 set again", v, 6);
      end
      @(negedge clk_rtc); src_req = '0;

      // R9 field widths and spare address
      wr(2'd1, 8'hFF);
      rd(2'd1, v); chk("R9 mask width", v, 15);
      rd(2'd3, v); chk("R9 spare reads zero", v, 0);
      chk("R5 irq on", int'(irq), 1);

      // R1 reset mid-run
      @(negedge clk_cpu); rst = 1'b1;
      repeat (3) @(negedge clk_cpu);
      chk("R1 irq in reset", int'(irq), 0);
      rst = 1'b0;
      @(negedge clk_cpu);
      rd(2'd0, v); chk("R1 reload after reset", v, 255);
      rd(2'd1, v); chk("R1 mask after reset", v, 0);
      rd(2'd2, v); chk("R1 req after reset", v, 0);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk_cpu);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule